// File: doc/BRIEF.md
# Contrast and Backlight PWM Generator

This block produces one pulse-width-modulated pin for driving a panel contrast input or a backlight stage through an external filter. Software programs a small register pair: a control word holding a clock prescale select, an output polarity and an enable, and a duty word holding an 8-bit compare value. An 8-bit counter advances once per prescaled tick. The pin is active while the counter is below the duty value, and polarity decides whether active means high or low.

While the block is disabled, the pin rests at the inactive level for the chosen polarity. The counter is held at zero and the working duty copy tracks the duty register. A duty write made while the block runs is staged and takes effect only when the counter wraps, so no period is ever cut short or stretched. Both registers read back through the same bus.

Top module: `contrast_pwm`

## Requirements
- R1: After reset the duty register reads 0xC8, the control register reads 0x04 (divide by 1, active-high, disabled), and `pwm_out` is low.
- R2: A write with `addr`=0 updates the control word: bits [1:0] are the prescale select, bit 2 is the polarity (1 = active high), and bit 3 is the enable. Bits [7:4] are ignored and read as zero. A write with `addr`=1 sets the duty. `rd_data` shows the register chosen by `addr`.
- R3: While enabled, one PWM period lasts 256 × 2^sel clock cycles and contains exactly duty × 2^sel active cycles, for every duty and every select value 0 to 3.
- R4: A duty of 0x00 gives no active cycle at all, and a duty of 0xFF leaves exactly one counter step per period inactive.
- R5: With the polarity bit at 0, the active level is low. The count of low cycles per period then follows R3.
- R6: From the second clock edge after a write that clears the enable, `pwm_out` holds the inactive level: low for polarity 1, high for polarity 0.
- R7: A duty written while enabled changes the output only from the next counter wrap. The period in progress completes with the old value.
- R8: An enable write starts the counter from zero with the current duty. The first active phase begins one clock after the write and lasts duty × 2^sel cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 duty |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| pwm_out | output | 1 | Modulated output pin |

## Verification
A counter that skips or repeats a value changes the number of active cycles in a period, and so does a prescaler tick that comes early or late. Either fault therefore appears as a wrong count within a single period of 256 × 2^sel cycles. A working duty copy that reloads at the wrong moment shows up in the period containing the write, because that period's active count then mixes the old and new duty values. An idle level or polarity fault is visible at the pin two cycles after the control write and stays visible for as long as the block is disabled.

// File: rtl/contrast_pwm_pkg.sv
// Package: shared register addresses and reset constants for the contrast PWM.
// Assumes a two-entry register space selected by a single address bit.
package contrast_pwm_pkg;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_DUTY = 1'b1
    } reg_sel_e;

    localparam int unsigned DEF_DUTY_W = 8;
    localparam int unsigned DEF_PSC_W  = 2;
    localparam logic [7:0]  DEF_DUTY   = 8'hC8;

endpackage

// File: rtl/pwm_regs.sv
// Module: control and duty register pair with read mux.
// Assumes DUTY_W >= PSC_W + 2 so the control word fits in the read path.
module pwm_regs
    import contrast_pwm_pkg::*;
#(
    parameter int unsigned          DUTY_W   = DEF_DUTY_W,
    parameter int unsigned          PSC_W    = DEF_PSC_W,
    parameter logic [DUTY_W-1:0]    DUTY_RST = DUTY_W'(DEF_DUTY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DUTY_W-1:0] wr_data,
    output logic [DUTY_W-1:0] rd_data,
    output logic [PSC_W-1:0]  psc_sel,
    output logic              pol_high,
    output logic              enable,
    output logic [DUTY_W-1:0] duty
);
    localparam int unsigned POL_BIT = PSC_W;
    localparam int unsigned EN_BIT  = PSC_W + 1;
    localparam int unsigned CTRL_W  = PSC_W + 2;

    logic [CTRL_W-1:0] ctrl_q;

    // Control word: prescale select, polarity (reset active high), enable (reset off).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_W'(1) << POL_BIT;
        end else if (wr_en && reg_sel_e'(addr) == REG_CTRL) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    // Duty word, reset to its default brightness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty <= DUTY_RST;
        end else if (wr_en && reg_sel_e'(addr) == REG_DUTY) begin
            duty <= wr_data;
        end
    end

    // Read mux, control word zero-extended.
    always_comb begin
        if (reg_sel_e'(addr) == REG_DUTY) begin
            rd_data = duty;
        end else begin
            rd_data = {{(DUTY_W-CTRL_W){1'b0}}, ctrl_q};
        end
    end

    assign psc_sel  = ctrl_q[PSC_W-1:0];
    assign pol_high = ctrl_q[POL_BIT];
    assign enable   = ctrl_q[EN_BIT];

endmodule

// File: rtl/pwm_prescaler.sv
// Module: tick generator dividing the clock by 2^sel.
// Assumes a select change may land mid-count; a count at or past the limit ticks at once.
module pwm_prescaler #(
    parameter int unsigned PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned CW = (1 << PSC_W) - 1;

    logic [CW-1:0] pcnt;
    logic [CW-1:0] limit;

    // Terminal count for the selected ratio.
    always_comb begin
        limit = (CW'(1) << sel) - CW'(1);
    end

    assign tick = run && (pcnt >= limit);

    // Cycle counter, cleared while stopped and on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + CW'(1);
        end
    end

endmodule

// File: rtl/pwm_core.sv
// Module: period counter, staged duty copy and registered polarity-aware output.
// Assumes tick is low whenever en is low.
module pwm_core #(
    parameter int unsigned       DUTY_W   = 8,
    parameter logic [DUTY_W-1:0] DUTY_RST = 8'hC8,
    parameter logic              OUT_RST  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pol_high,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [DUTY_W-1:0] cnt,
    output logic [DUTY_W-1:0] duty_act,
    output logic              pwm_out
);
    localparam logic [DUTY_W-1:0] CNT_TOP = '1;

    logic on_phase;

    // Counter and working duty: duty tracks while stopped, reloads only at wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            duty_act <= DUTY_RST;
        end else if (!en) begin
            cnt      <= '0;
            duty_act <= duty_in;
        end else if (tick) begin
            cnt <= cnt + DUTY_W'(1);
            if (cnt == CNT_TOP) begin
                duty_act <= duty_in;
            end
        end
    end

    assign on_phase = en && (cnt < duty_act);

    // Registered pin with polarity applied; disabled maps to the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out <= OUT_RST;
        end else begin
            pwm_out <= pol_high ? on_phase : !on_phase;
        end
    end

endmodule

// File: rtl/contrast_pwm.sv
// Module: top of the contrast/backlight PWM generator.
// Assumes a single clock; register writes act on the next edge.
module contrast_pwm
    import contrast_pwm_pkg::*;
#(
    parameter int unsigned       DUTY_W   = DEF_DUTY_W,
    parameter int unsigned       PSC_W    = DEF_PSC_W,
    parameter logic [DUTY_W-1:0] DUTY_RST = DUTY_W'(DEF_DUTY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DUTY_W-1:0] wr_data,
    output logic [DUTY_W-1:0] rd_data,
    output logic              pwm_out
);
    logic [PSC_W-1:0]  psc_sel;
    logic              pol_high;
    logic              enable;
    logic [DUTY_W-1:0] duty_reg;
    logic              tick;
    logic [DUTY_W-1:0] core_cnt;
    logic [DUTY_W-1:0] core_duty;

    pwm_regs #(
        .DUTY_W   (DUTY_W),
        .PSC_W    (PSC_W),
        .DUTY_RST (DUTY_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .psc_sel  (psc_sel),
        .pol_high (pol_high),
        .enable   (enable),
        .duty     (duty_reg)
    );

    pwm_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .sel   (psc_sel),
        .tick  (tick)
    );

    pwm_core #(
        .DUTY_W   (DUTY_W),
        .DUTY_RST (DUTY_RST),
        .OUT_RST  (1'b0)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .pol_high (pol_high),
        .tick     (tick),
        .duty_in  (duty_reg),
        .cnt      (core_cnt),
        .duty_act (core_duty),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/contrast_pwm_chk.sv
// Module: assertion checker bound into contrast_pwm.
// Assumes reset is held for at least one edge before release.
module contrast_pwm_chk #(
    parameter int unsigned DUTY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              addr,
    input logic [DUTY_W-1:0] wr_data,
    input logic              enable,
    input logic              pol_high,
    input logic              tick,
    input logic [DUTY_W-1:0] core_cnt,
    input logic [DUTY_W-1:0] core_duty,
    input logic [DUTY_W-1:0] duty_reg,
    input logic              pwm_out
);
    localparam logic [DUTY_W-1:0] TOP = '1;

    // R6: disabled in the previous cycle means the pin shows the inactive level.
    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (pwm_out == !$past(pol_high)));

    // R7: working duty changes only at a wrap or while stopped.
    p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_duty) |-> (($past(core_cnt) == TOP && $past(tick)) || !$past(enable)));

    // R3: each tick moves the counter by exactly one.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && enable && $past(tick)) |-> (core_cnt == DUTY_W'($past(core_cnt) + 1'b1)));

    // R8: a stopped block leaves the counter at zero.
    p_count_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (core_cnt == '0));

    // R2: a duty write lands in the duty register on the next edge.
    p_duty_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr) |-> (duty_reg == $past(wr_data)));

endmodule

bind contrast_pwm contrast_pwm_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .enable    (enable),
    .pol_high  (pol_high),
    .tick      (tick),
    .core_cnt  (core_cnt),
    .core_duty (core_duty),
    .duty_reg  (duty_reg),
    .pwm_out   (pwm_out)
);

// File: tb/tb_contrast_pwm.sv
`timescale 1ns/1ps
// Bench: period-count sweeps over duty and prescale, plus polarity, idle and staging cases.
module tb_contrast_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    contrast_pwm dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    // Record one check.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Register write; called and returning at a falling edge.
    task automatic wr(input bit a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count samples at the given level over n falling edges.
    task automatic measure(input int n, input logic lvl, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out == lvl) c++;
            @(negedge clk);
        end
    endtask

    // Watchdog.
    initial begin
        #(200000 * 20);
        n_total++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int c;
        int per;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        addr = 1'b1; #1;
        check(rd_data == 8'hC8, "R1 duty reset", rd_data, 8'hC8);
        addr = 1'b0; #1;
        check(rd_data == 8'h04, "R1 ctrl reset", rd_data, 8'h04);
        check(pwm_out == 1'b0, "R1 output reset", pwm_out, 0);
        @(negedge clk);

        // R2 readback, upper control bits ignored
        wr(1'b0, 8'hF6);
        addr = 1'b0; #1;
        check(rd_data == 8'h06, "R2 ctrl readback", rd_data, 8'h06);
        wr(1'b1, 8'h5A);
        addr = 1'b1; #1;
        check(rd_data == 8'h5A, "R2 duty readback", rd_data, 8'h5A);
        wr(1'b0, 8'h04);

        // R8 and R7: staged duty at divide by 1
        wr(1'b1, 8'h40);
        wr(1'b0, 8'h0C);
        c = 0;
        for (int i = 0; i <= 256; i++) begin
            if (pwm_out) c++;
            if (i == 100) begin wr_en = 1'b1; addr = 1'b1; wr_data = 8'hC0; end
            if (i == 101) wr_en = 1'b0;
            @(negedge clk);
        end
        check(c == 64, "R8 first period from enable", c, 64);
        check(c == 64, "R7 old duty kept until wrap", c, 64);
        measure(256, 1'b1, c);
        check(c == 192, "R7 new duty after wrap", c, 192);

        // R3/R4 sweeps: every fifth duty at /1, corner set at /2,/4,/8
        for (int s = 0; s < 4; s++) begin
            per = 256 << s;
            wr(1'b0, 8'h04);
            wr(1'b0, 8'h0C | 8'(s));
            if (s == 0) begin
                for (int d = 0; d < 256; d += 5) begin
                    wr(1'b1, 8'(d));
                    repeat (per + 4) @(negedge clk);
                    measure(per, 1'b1, c);
                    check(c == d, (d == 0 || d == 255) ? "R4 duty extreme" : "R3 duty /1", c, d);
                end
            end else begin
                for (int k = 0; k < 6; k++) begin
                    int d;
                    case (k)
                        0: d = 0;
                        1: d = 1;
                        2: d = 100;
                        3: d = 200;
                        4: d = 254;
                        default: d = 255;
                    endcase
                    wr(1'b1, 8'(d));
                    repeat (per + 4) @(negedge clk);
                    measure(per, 1'b1, c);
                    check(c == d << s, (d == 0 || d == 255) ? "R4 duty extreme scaled" : "R3 duty scaled", c, d << s);
                end
            end
        end

        // R5 inverted polarity, /1 and /4
        wr(1'b0, 8'h04);
        wr(1'b1, 8'h50);
        wr(1'b0, 8'h08);
        repeat (260) @(negedge clk);
        measure(256, 1'b0, c);
        check(c == 8'h50, "R5 low cycles /1", c, 8'h50);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h0A);
        repeat (1030) @(negedge clk);
        measure(1024, 1'b0, c);
        check(c == 8'h50 * 4, "R5 low cycles /4", c, 8'h50 * 4);

        // R6 idle level, both polarities
        wr(1'b1, 8'h80);
        wr(1'b0, 8'h0C);
        repeat (300) @(negedge clk);
        wr(1'b0, 8'h04);
        @(negedge clk);
        measure(300, 1'b0, c);
        check(c == 300, "R6 idle low when active-high", c, 300);
        wr(1'b0, 8'h00);
        @(negedge clk);
        measure(300, 1'b1, c);
        check(c == 300, "R6 idle high when active-low", c, 300);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule